// File: doc/BRIEF.md
# Radix-4 Carry-Save Modular Multiplier

This block forms the modular product A·B mod N for an N_BITS-wide modulus whose top bit is set, with both operands already reduced below the modulus. It walks the multiplier B from its most significant end, two bits per cycle. Each step scales the running remainder by four, adds 0, A, 2A or 3A, and removes an estimated multiple of N. The running remainder stays in carry-save form (two vectors) for the whole loop, so no carry has to ripple across the full width while the loop runs.

The multiple of N to remove is picked from a short sum of the top bits of the two carry-save vectors. That sum is compared against small thresholds derived from the top bits of N. The estimate never removes too much, so the remainder never goes negative. It never removes too little by more than a bounded amount, which keeps the remainder below 1.32·N. After the loop, one cycle merges the two vectors with a full-width adder, and one more cycle subtracts N if needed. The caller loads the three operands in parallel with a single-cycle start, then waits for a one-cycle done, which carries the result.

Top module: `radix4_modmul`

## Requirements
- R1: While reset is asserted and after its release, before any start, done is 0 and product is all zeros.
- R2: start is taken only when the unit is idle, and the operands are captured on that edge. A start raised while a multiplication is in progress is ignored, and the operand inputs may change freely during the run.
- R3: For 2^(N_BITS-1) ≤ modulus < 2^N_BITS and op_a, op_b < modulus, the product presented with done equals op_a·op_b mod modulus.
- R4: done rises exactly N_BITS/2 + 3 clock cycles after the rising edge that accepted start: one cycle for the 3A/3N precompute, N_BITS/2 loop cycles, one for carry merging and one for correction.
- R5: done is high for exactly one cycle per accepted start.
- R6: product changes only in a cycle where done is high, and otherwise holds its last value, including while idle.
- R7: The partial remainder is kept in carry-save form and stays non-negative and below 2·modulus through to the correction step, so one conditional subtraction of the modulus gives a result below the modulus. This holds even for the largest operands, such as modulus = 2^N_BITS − 1 with op_a = op_b = modulus − 1 (result 1).
- R8: The cycle in which done is high counts as idle, so a start given in that cycle is accepted. The next result then follows with the R4 latency.
- R9: op_a = 0 gives 0, and op_b = modulus − 1 gives modulus − op_a for nonzero op_a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication (sampled when idle) |
| op_a | input | N_BITS | Multiplicand, below modulus |
| op_b | input | N_BITS | Multiplier, below modulus |
| modulus | input | N_BITS | Modulus, top bit set |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | N_BITS | op_a·op_b mod modulus, held until the next done |

## Verification
Two functions can fall in one cycle: delivering a result with done, and accepting the next start. The bench provokes this by driving every new operation in the very cycle in which done of the previous one is seen. The scoreboard then judges both sides. The outgoing product must match its own reference, and the incoming operation must produce its reference value with done exactly N_BITS/2 + 3 cycles after that shared cycle's edge. Both widths (32 and 64 bits) are run with random operands, with the extreme moduli and operands, and with start pulses injected mid-run that must leave the result untouched.

// File: rtl/radix4_modmul.sv
module radix4_modmul #(
  parameter int N_BITS   = 64,
  parameter int EST_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_BITS-1:0] op_a,
  input  logic [N_BITS-1:0] op_b,
  input  logic [N_BITS-1:0] modulus,
  output logic              done,
  output logic [N_BITS-1:0] product
);

  localparam int W    = N_BITS + 5;
  localparam int T    = N_BITS - EST_BITS;
  localparam int VE_W = W - T;
  localparam int ITER = N_BITS / 2;
  localparam int CW   = (ITER > 2) ? $clog2(ITER) : 1;

  typedef enum logic [2:0] {IDLE, PRE, LOOP, CPA, FIX} st_t;

  st_t               st_q;
  logic [CW-1:0]     cnt_q;
  logic [N_BITS-1:0] a_q, b_q, n_q;
  logic [W-1:0]      a3_q, n3_q, s_q, c_q, rsum_q;

  logic [W-1:0] a_w, n_w;
  assign a_w = W'(a_q);
  assign n_w = W'(n_q);

  // partial product row: 4R + digit*A
  logic [1:0]   dig;
  logic [W-1:0] xa, x4s, x4c, s1, c1, maj1;
  assign dig = b_q[N_BITS-1 -: 2];
  assign x4s = s_q << 2;
  assign x4c = c_q << 2;

  always_comb begin
    case (dig)
      2'd0:    xa = '0;
      2'd1:    xa = a_w;
      2'd2:    xa = a_w << 1;
      default: xa = a3_q;
    endcase
  end

  assign s1   = x4s ^ x4c ^ xa;
  assign maj1 = (x4s & x4c) | (x4s & xa) | (x4c & xa);
  assign c1   = maj1 << 1;

  // quotient estimate from top bits only
  logic [VE_W-1:0]     ve, th, th9;
  logic [EST_BITS:0]   nt1;
  logic [3:0]          q;
  assign ve  = s1[W-1:T] + c1[W-1:T];
  assign nt1 = {1'b0, n_q[N_BITS-1 -: EST_BITS]} + (EST_BITS+1)'(1);
  assign th9 = VE_W'(nt1) * VE_W'(9);

  always_comb begin
    q  = '0;
    th = '0;
    for (int k = 1; k <= 8; k++) begin
      th = VE_W'(nt1) * VE_W'(k);
      if ($signed(ve) >= $signed(th)) q = q + 4'd1;
    end
  end

  // subtract q*N as (q[1:0])*N + (q[3:2])*4N in two carry-save rows
  logic [W-1:0] m_lo, m_hi, s2, c2, maj2, s3, c3, maj3;

  always_comb begin
    case (q[1:0])
      2'd0:    m_lo = '0;
      2'd1:    m_lo = n_w;
      2'd2:    m_lo = n_w << 1;
      default: m_lo = n3_q;
    endcase
    if (q[3])      m_hi = n_w << 3;
    else if (q[2]) m_hi = n_w << 2;
    else           m_hi = '0;
  end

  assign s2   = s1 ^ c1 ^ ~m_lo;
  assign maj2 = (s1 & c1) | (s1 & ~m_lo) | (c1 & ~m_lo);
  assign c2   = W'({maj2, 1'b1});
  assign s3   = s2 ^ c2 ^ ~m_hi;
  assign maj3 = (s2 & c2) | (s2 & ~m_hi) | (c2 & ~m_hi);
  assign c3   = W'({maj3, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= IDLE;
      cnt_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      n_q     <= '0;
      a3_q    <= '0;
      n3_q    <= '0;
      s_q     <= '0;
      c_q     <= '0;
      rsum_q  <= '0;
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        IDLE: if (start) begin
          a_q  <= op_a;
          b_q  <= op_b;
          n_q  <= modulus;
          st_q <= PRE;
        end
        PRE: begin
          a3_q  <= a_w + (a_w << 1);
          n3_q  <= n_w + (n_w << 1);
          s_q   <= '0;
          c_q   <= '0;
          cnt_q <= '0;
          st_q  <= LOOP;
        end
        LOOP: begin
          s_q   <= s3;
          c_q   <= c3;
          b_q   <= b_q << 2;
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(ITER - 1)) st_q <= CPA;
        end
        CPA: begin
          rsum_q <= s_q + c_q;
          st_q   <= FIX;
        end
        default: begin
          product <= (rsum_q >= n_w) ? N_BITS'(rsum_q - n_w) : N_BITS'(rsum_q);
          done    <= 1'b1;
          st_q    <= IDLE;
        end
      endcase
    end
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == IDLE && start) |=> (st_q == PRE)); // R2

  AST_EST_NO_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LOOP) |-> ($signed(ve) < $signed(th9))); // R7

  AST_REM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FIX) |-> (rsum_q < (n_w << 1))); // R7

  AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product < n_q)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> done); // R6

endmodule

// File: tb/tb_radix4_modmul.sv
`timescale 1ns/1ps
module tb_radix4_modmul;
  localparam int L64 = 64/2 + 3;
  localparam int L32 = 32/2 + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st64 = 1'b0, st32 = 1'b0;
  logic [63:0] a64 = '0, b64 = '0, m64 = '0;
  logic [31:0] a32 = '0, b32 = '0, m32 = '0;
  logic        done64, done32;
  logic [63:0] p64;
  logic [31:0] p32;

  always #4 clk = ~clk;

  radix4_modmul #(.N_BITS(64)) dut (
    .clk(clk), .rst_n(rst_n), .start(st64), .op_a(a64), .op_b(b64),
    .modulus(m64), .done(done64), .product(p64));

  radix4_modmul #(.N_BITS(32)) dut32 (
    .clk(clk), .rst_n(rst_n), .start(st32), .op_a(a32), .op_b(b32),
    .modulus(m32), .done(done32), .product(p32));

  typedef struct { logic [63:0] v; int due; string tag; } item_t;
  item_t q64[$], q32[$];

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit prev64 = 1'b0, prev32 = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mod(logic [63:0] a, logic [63:0] b, logic [63:0] n);
    logic [127:0] p;
    p = {64'b0, a} * {64'b0, b};
    return 64'(p % {64'b0, n});
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic go64(logic [63:0] a, logic [63:0] b, logic [63:0] n, string tag, bit poke);
    a64 = a; b64 = b; m64 = n; st64 = 1'b1;
    q64.push_back('{ref_mod(a, b, n), cyc + 1 + L64, tag});
    @(negedge clk);
    st64 = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      a64 = ~a; b64 = b ^ 64'd1; m64 = n ^ 64'h2; st64 = 1'b1;
      @(negedge clk);
      st64 = 1'b0;
    end
    while (!done64) @(negedge clk);
  endtask

  task automatic go32(logic [31:0] a, logic [31:0] b, logic [31:0] n, string tag, bit poke);
    a32 = a; b32 = b; m32 = n; st32 = 1'b1;
    q32.push_back('{ref_mod({32'b0, a}, {32'b0, b}, {32'b0, n}), cyc + 1 + L32, tag});
    @(negedge clk);
    st32 = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      a32 = ~a; b32 = b ^ 32'd1; m32 = n ^ 32'h2; st32 = 1'b1;
      @(negedge clk);
      st32 = 1'b0;
    end
    while (!done32) @(negedge clk);
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (done64) begin
        if (q64.size() == 0) chk(1'b0, "R5 done without start (64)", 64'd1, 64'd0);
        else begin
          item_t it;
          it = q64.pop_front();
          chk(p64 == it.v, {it.tag, " value (64)"}, p64, it.v);
          chk(cyc == it.due, "R4 latency (64)", 64'(cyc), 64'(it.due));
        end
      end
      if (done64 && prev64) chk(1'b0, "R5 done longer than one cycle (64)", 64'd1, 64'd0);
      prev64 = done64;
      if (done32) begin
        if (q32.size() == 0) chk(1'b0, "R5 done without start (32)", 64'd1, 64'd0);
        else begin
          item_t it;
          it = q32.pop_front();
          chk({32'b0, p32} == it.v, {it.tag, " value (32)"}, {32'b0, p32}, it.v);
          chk(cyc == it.due, "R4 latency (32)", 64'(cyc), 64'(it.due));
        end
      end
      if (done32 && prev32) chk(1'b0, "R5 done longer than one cycle (32)", 64'd1, 64'd0);
      prev32 = done32;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] n, a, b, last;
    logic [31:0] n3, a3, b3;
    repeat (3) @(negedge clk);
    chk(done64 == 1'b0, "R1 done in reset (64)", {63'b0, done64}, 64'd0);
    chk(p64 == 64'd0, "R1 product in reset (64)", p64, 64'd0);
    chk(done32 == 1'b0, "R1 done in reset (32)", {63'b0, done32}, 64'd0);
    chk(p32 == 32'd0, "R1 product in reset (32)", {32'b0, p32}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done64 == 1'b0 && p64 == 64'd0, "R1 idle after reset (64)", p64, 64'd0);

    // corner cases, 64 bit, issued back to back (R8)
    n = 64'hFFFF_FFFF_FFFF_FFFF;
    go64(n - 64'd1, n - 64'd1, n, "R7 max operands", 1'b0);
    go64(64'd0, 64'h1234_5678_9ABC_DEF0, n, "R9 zero multiplicand R8", 1'b0);
    go64(64'h0F0F_0F0F_0F0F_0F0F, n - 64'd1, n, "R9 multiplier N-1 R8", 1'b0);
    n = 64'h8000_0000_0000_0001;
    go64(n - 64'd1, n - 64'd1, n, "R7 smallest top modulus", 1'b0);
    go64(64'd1, 64'd1, n, "R3 unit", 1'b0);

    for (int i = 0; i < 40; i++) begin
      n = rnd64() | 64'h8000_0000_0000_0001;
      a = rnd64() % n;
      b = rnd64() % n;
      go64(a, b, n, (i % 4 == 0) ? "R2 busy start ignored" : "R3 random R8", i % 4 == 0);
    end

    // idle hold (R6)
    n = 64'hC000_0000_0000_0013;
    a = 64'h7777_0000_1111_2222;
    b = 64'h0123_4567_89AB_CDEF;
    last = ref_mod(a, b, n);
    go64(a, b, n, "R3 before hold", 1'b0);
    repeat (8) @(negedge clk);
    chk(p64 == last, "R6 product held while idle", p64, last);
    chk(done64 == 1'b0, "R5 done low while idle", {63'b0, done64}, 64'd0);
    a64 = 64'd5; b64 = 64'd7; m64 = 64'hFFFF_FFFF_FFFF_FFC5;
    repeat (3) @(negedge clk);
    chk(p64 == last, "R6 product ignores input changes", p64, last);

    // 32 bit
    n3 = 32'hFFFF_FFFF;
    go32(n3 - 32'd1, n3 - 32'd1, n3, "R7 max operands", 1'b0);
    go32(32'd0, 32'hDEAD_BEEF % n3, n3, "R9 zero multiplicand", 1'b0);
    go32(32'h1357_9BDF, n3 - 32'd1, n3, "R9 multiplier N-1", 1'b0);
    n3 = 32'h8000_0001;
    go32(n3 - 32'd1, n3 - 32'd2, n3, "R7 smallest top modulus", 1'b0);
    for (int i = 0; i < 40; i++) begin
      n3 = $urandom() | 32'h8000_0001;
      a3 = $urandom() % n3;
      b3 = $urandom() % n3;
      go32(a3, b3, n3, (i % 5 == 0) ? "R2 busy start ignored" : "R3 random R8", i % 5 == 0);
    end

    repeat (4) @(negedge clk);
    chk(q64.size() == 0, "R4 outstanding results (64)", 64'(q64.size()), 64'd0);
    chk(q32.size() == 0, "R4 outstanding results (32)", 64'(q32.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule